// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is a slave receiver for two-channel serial audio. It listens to an externally driven bit clock, frame clock and data line, recovers the left and right samples of each stereo frame, and hands them to logic running on the system clock. Four framings are understood: I2S, left-justified, right-justified and a DSP-style framing in which the frame clock toggles at twice the sample rate and never says which channel is present. Each of them works with 16-, 20- or 24-bit words.

Samples arrive most significant bit first in two's-complement form. Every word is sign-extended to 24 bits. A finished left/right pair is captured in the bit-clock domain and carried into the system domain through a toggle handshake, where it appears together with a one-cycle valid strobe. The framing and word-length selects are expected to come from control registers. They are changed only while the block is held in reset.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high, and on the first system clock after it, `pair_valid` is 0 and both sample outputs are 0.
- R2: With `fmt_sel` = 2'b00 (I2S, the reset default) the MSB is taken one bit clock after a frame-clock transition, and the word sent while the frame clock is low is the left sample.
- R3: With `fmt_sel` = 2'b11 (left-justified) the MSB is the bit sampled on the first bit clock at which the new frame-clock level is seen, and the word sent while the frame clock is high is the left sample.
- R4: With `fmt_sel` = 2'b01 (right-justified) the LSB is the last bit sampled before a frame-clock transition, the word is the selected number of bits counted back from that point, and the word sent while the frame clock is high is the left sample.
- R5: With `fmt_sel` = 2'b10 (DSP) every rising frame-clock edge opens a word whose MSB comes one bit clock later. The words alternate left, right, left, and so on, and the first word after reception begins is left.
- R6: `width_sel` = 2'b00 selects 24 bits, 2'b01 selects 20 bits, and 2'b10 or 2'b11 select 16 bits. A shorter word is sign-extended to 24 bits on the outputs.
- R7: Bit-clock slots outside the word have no effect on the delivered samples.
- R8: After `rst` is released, nothing is received until the first rising edge of the frame clock. Words that end before reception has begun are never delivered.
- R9: A pair is delivered only when a right word completes after a left word that was captured since the previous pair. A right word with no left word before it is dropped.
- R10: Each pair appears on `left_out`/`right_out` with `pair_valid` high for exactly one system clock. Both outputs hold their value until the next strobe.
- R11: Pauses of the bit clock between bits, with the frame clock and data held steady, do not change the delivered samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset. It is also carried into the bit-clock domain. |
| fmt_sel | input | 2 | Framing select: 00 I2S, 01 right-justified, 10 DSP, 11 left-justified |
| width_sel | input | 2 | Word length select: 00 = 24, 01 = 20, 1x = 16 |
| bclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrclk | input | 1 | Frame clock from the transmitter |
| sdata | input | 1 | Serial data, MSB first |
| left_out | output | 24 | Sign-extended left sample of the last pair |
| right_out | output | 24 | Sign-extended right sample of the last pair |
| pair_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
If the framing logic starts a word one bit early or late, every delivered sample comes out scaled by two or with bits shifted in from the slot around it. The bench compares the first pair after each such start with its own serialised values, so the error shows on the first strobe. If the channel assignment or the DSP slot alternation goes wrong, left and right swap, or a pair is dropped or repeated, and this shows one frame later as a mismatch or as a pair left over in the expected queue. If the handshake goes wrong, the strobe lasts too long or the outputs change without a strobe. The bench checks the outputs on every system clock, so this shows within a cycle.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = $clog2(SAMPLE_W + 1);

    typedef logic [SAMPLE_W-1:0] sample_t;

    // framing select codes, decoded by the receiver
    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_DSP = 2'b10,
        FMT_LJ  = 2'b11
    } frame_fmt_e;

    typedef enum logic [1:0] {
        WL_24  = 2'b00,
        WL_20  = 2'b01,
        WL_16A = 2'b10,
        WL_16B = 2'b11
    } word_len_e;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    function automatic logic [CNT_W-1:0] word_bits(word_len_e wl);
        case (wl)
            WL_24:   return CNT_W'(24);
            WL_20:   return CNT_W'(20);
            default: return CNT_W'(16);
        endcase
    endfunction

    // sign-extend the low word of a shift register to the full sample width
    function automatic sample_t extend_word(sample_t raw, word_len_e wl);
        case (wl)
            WL_24:   return raw;
            WL_20:   return {{(SAMPLE_W-20){raw[19]}}, raw[19:0]};
            default: return {{(SAMPLE_W-16){raw[15]}}, raw[15:0]};
        endcase
    endfunction

endpackage

// File: rtl/sarx_frame.sv
module sarx_frame
    import sarx_pkg::*;
#(
    parameter int RST_STAGES = 2
) (
    input  logic       bclk,
    input  logic       rst,
    input  frame_fmt_e fmt,
    input  word_len_e  wlen,
    input  logic       lrclk,
    input  logic       sdata,
    output stereo_t    pair,
    output logic       pair_tgl
);

    logic [RST_STAGES-1:0] rst_pipe;
    logic                  rst_b;

    logic             lr_q, lr_qq;
    logic             armed, dsp_next, cur_right, active, have_left;
    logic [CNT_W-1:0] cnt, bits_now, wbits;
    sample_t          shreg, shreg_nx, left_hold, done_raw, done_word;
    logic             lr_rise, live, start, start_right, done, done_right;

    // reset carried into the bit-clock domain
    always_ff @(posedge bclk) rst_pipe <= {rst_pipe[RST_STAGES-2:0], rst};
    assign rst_b = rst_pipe[RST_STAGES-1];

    assign lr_rise  = lrclk & ~lr_q;
    assign live     = armed | lr_rise;
    assign wbits    = word_bits(wlen);
    assign shreg_nx = {shreg[SAMPLE_W-2:0], sdata};
    assign bits_now = cnt + CNT_W'(1);

    // word start detection per framing
    always_comb begin
        start       = 1'b0;
        start_right = 1'b0;
        case (fmt)
            FMT_LJ: begin
                start       = lrclk ^ lr_q;
                start_right = ~lrclk;
            end
            FMT_I2S: begin
                start       = lr_q ^ lr_qq;
                start_right = lr_q;
            end
            FMT_DSP: begin
                start       = lr_q & ~lr_qq;
                start_right = dsp_next;
            end
            default: ;
        endcase
        start = start & live;
    end

    // word completion: counted forward, or taken back from the edge
    always_comb begin
        done       = 1'b0;
        done_right = 1'b0;
        done_raw   = shreg_nx;
        if (fmt == FMT_RJ) begin
            done       = armed & (lrclk ^ lr_q);
            done_right = ~lr_q;
            done_raw   = shreg;
        end else if (active && !start && bits_now == wbits) begin
            done       = 1'b1;
            done_right = cur_right;
        end
    end

    assign done_word = extend_word(done_raw, wlen);

    always_ff @(posedge bclk) begin
        if (rst_b) begin
            lr_q      <= lrclk;
            lr_qq     <= lrclk;
            armed     <= 1'b0;
            dsp_next  <= 1'b0;
            cur_right <= 1'b0;
            active    <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            left_hold <= '0;
            have_left <= 1'b0;
            pair      <= '0;
            pair_tgl  <= 1'b0;
        end else begin
            lr_q  <= lrclk;
            lr_qq <= lr_q;
            shreg <= shreg_nx;
            if (lr_rise) armed <= 1'b1;
            if (start) begin
                active    <= 1'b1;
                cnt       <= CNT_W'(1);
                cur_right <= start_right;
                if (fmt == FMT_DSP) dsp_next <= ~dsp_next;
            end else if (active) begin
                cnt <= bits_now;
                if (bits_now == wbits) active <= 1'b0;
            end
            if (done) begin
                if (!done_right) begin
                    left_hold <= done_word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    pair.left  <= left_hold;
                    pair.right <= done_word;
                    pair_tgl   <= ~pair_tgl;
                    have_left  <= 1'b0;
                end
            end
        end
    end

    // R8: no pair leaves before the first rising frame edge
    p_quiet_before_arm_r8: assert property (@(posedge bclk) disable iff (rst || rst_b)
        !armed |=> $stable(pair_tgl));

    // R6: an open word never holds more bits than the selected width
    p_count_in_word_r6: assert property (@(posedge bclk) disable iff (rst || rst_b)
        active |-> (cnt != '0) && (cnt < wbits));

    // R9: a pair is only released while a left word is waiting
    p_pair_needs_left_r9: assert property (@(posedge bclk) disable iff (rst || rst_b)
        (pair_tgl != $past(pair_tgl)) |-> $past(have_left));

endmodule

// File: rtl/sarx_xfer.sv
module sarx_xfer
    import sarx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  stereo_t pair_in,
    input  logic    tgl_in,
    output stereo_t pair_out,
    output logic    valid
);

    logic [SYNC_STAGES-1:0] sync;
    logic                   seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync     <= '0;
            seen     <= 1'b0;
            pair_out <= '0;
            valid    <= 1'b0;
        end else begin
            sync  <= {sync[SYNC_STAGES-2:0], tgl_in};
            seen  <= sync[SYNC_STAGES-1];
            valid <= 1'b0;
            // the pair is held stable in the bit domain for a whole frame
            if (sync[SYNC_STAGES-1] ^ seen) begin
                pair_out <= pair_in;
                valid    <= 1'b1;
            end
        end
    end

    // R10: the strobe lasts one system clock
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R10: outputs move only together with the strobe
    p_hold_between_r10: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(pair_out));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          width_sel,
    input  logic                bclk,
    input  logic                lrclk,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid
);

    frame_fmt_e fmt;
    word_len_e  wlen;
    stereo_t    bit_pair, sys_pair;
    logic       bit_tgl;

    assign fmt  = frame_fmt_e'(fmt_sel);
    assign wlen = word_len_e'(width_sel);

    sarx_frame #(.RST_STAGES(SYNC_STAGES)) u_frame (
        .bclk     (bclk),
        .rst      (rst),
        .fmt      (fmt),
        .wlen     (wlen),
        .lrclk    (lrclk),
        .sdata    (sdata),
        .pair     (bit_pair),
        .pair_tgl (bit_tgl)
    );

    sarx_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .pair_in  (bit_pair),
        .tgl_in   (bit_tgl),
        .pair_out (sys_pair),
        .valid    (pair_valid)
    );

    assign left_out  = sys_pair.left;
    assign right_out = sys_pair.right;

endmodule

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'b00;
    logic [1:0]  width_sel = 2'b00;
    logic        bclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_out, right_out;
    logic        pair_valid;

    serial_audio_rx uut (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .width_sel(width_sel),
        .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
        .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
    );

    always #2 clk = ~clk;

    int          checks = 0;
    int          fails = 0;
    int          bit_n = 0;
    int          seed = 0;
    bit          bursty = 1'b0;
    logic [47:0] exp_q[$];
    string       tag_q[$];
    logic [47:0] exp_v;
    string       exp_t;
    logic [23:0] last_l = '0, last_r = '0;

    function automatic logic [23:0] sx(logic [23:0] v, int w);
        logic [23:0] m;
        m = (24'h1 << w) - 24'h1;
        return v[w-1] ? ((v & m) | ~m) : (v & m);
    endfunction

    // reference comparison on every system clock (R9, R10)
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (pair_valid) begin
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R9: unexpected pair L=%h R=%h, expected none", left_out, right_out);
                end else begin
                    exp_v = exp_q.pop_front();
                    exp_t = tag_q.pop_front();
                    if ({left_out, right_out} !== exp_v) begin
                        fails++;
                        $display("FAIL %s: got L=%h R=%h expected L=%h R=%h",
                                 exp_t, left_out, right_out, exp_v[47:24], exp_v[23:0]);
                    end
                end
            end else if (left_out !== last_l || right_out !== last_r) begin
                fails++;
                $display("FAIL R10: outputs moved without strobe L=%h R=%h expected L=%h R=%h",
                         left_out, right_out, last_l, last_r);
            end
        end
        last_l = left_out;
        last_r = right_out;
    end

    // one bit-clock period; optional pause models a bursty clock (R11)
    task automatic send_bit(input logic l, input logic d);
        lrclk = l;
        sdata = d;
        #20 bclk = 1'b1;
        #20 bclk = 1'b0;
        bit_n++;
        if (bursty && (bit_n % 5 == 0)) #60;
    endtask

    task automatic send_frame(input logic [23:0] lv, input logic [23:0] rv,
                              input bit expect_it, input string tag);
        int w, j, p;
        logic l, d;
        logic [23:0] wd;
        w = (width_sel == 2'b00) ? 24 : (width_sel == 2'b01) ? 20 : 16;
        if (expect_it) begin
            exp_q.push_back({sx(lv, w), sx(rv, w)});
            tag_q.push_back(tag);
        end
        for (int i = 0; i < 64; i++) begin
            j  = i % 32;
            wd = (i >= 32) ? rv : lv;
            d  = (i % 3 == 1);          // junk outside the word (R7)
            case (fmt_sel)
                2'b00:   begin l = (i >= 32); p = j - 1;        end // I2S, R2
                2'b11:   begin l = (i < 32);  p = j;            end // LJ, R3
                2'b01:   begin l = (i < 32);  p = j - (32 - w); end // RJ, R4
                default: begin l = (j < 16);  p = j - 1;        end // DSP, R5
            endcase
            if (p >= 0 && p < w) d = wd[w-1-p];
            send_bit(l, d);
        end
    endtask

    task automatic session(input logic [1:0] f, input logic [1:0] wc, input bit b,
                           input int n, input string tag);
        logic [23:0] lv, rv;
        rst = 1'b1;
        fmt_sel = f;
        width_sel = wc;
        bursty = b;
        for (int k = 0; k < 8; k++) send_bit(1'b0, 1'b0);
        checks++;
        if (left_out !== '0 || right_out !== '0 || pair_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset L=%h R=%h V=%b expected 0 0 0", left_out, right_out, pair_valid);
        end
        rst = 1'b0;
        for (int k = 0; k < 6; k++) send_bit(1'b0, 1'b0);
        for (int k = 0; k < n; k++) begin
            case (seed % 5)
                0:       begin lv = 24'h800000; rv = 24'h7FFFFF; end
                1:       begin lv = 24'hFF8000; rv = 24'h007FFF; end
                default: begin lv = 24'h5A3C0F ^ (24'(seed) * 24'h01F7A3); rv = ~lv + 24'(seed * 3); end
            endcase
            seed++;
            // R8: in I2S the first frame's left word precedes the first rising edge
            send_frame(lv, rv, !(f == 2'b00 && k == 0), tag);
        end
        for (int k = 0; k < 4; k++) send_bit(1'b1, 1'b0);
        repeat (60) @(negedge clk);
        #1;
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d pairs missing in %s, expected 0", exp_q.size(), tag);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1;
        session(2'b00, 2'b00, 1'b0, 3, "R2 R6 R7 R8");
        session(2'b11, 2'b01, 1'b0, 3, "R3 R6 R7");
        session(2'b01, 2'b10, 1'b0, 3, "R4 R6 R7");
        session(2'b10, 2'b00, 1'b0, 3, "R5 R7");
        session(2'b11, 2'b00, 1'b1, 2, "R3 R11");
        session(2'b01, 2'b01, 1'b0, 2, "R4 R6");
        session(2'b10, 2'b11, 1'b1, 3, "R5 R6 R11");
        session(2'b00, 2'b10, 1'b1, 3, "R2 R9 R11");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule